// File: doc/BRIEF.md
# Vertical Sync Extractor

The block takes a clean one-bit, active-low composite sync signal that has already been sliced and digitized. It is sampled on the system clock, and the block emits one active-high vertical sync pulse per vertical interval. The sync level first passes through a two-flop synchroniser. The block then measures each low stretch of the synchronised signal in clock cycles. A stretch that stays low for the programmed threshold is taken as the broad pulse of a vertical interval, and this arms the pulse launcher.

Once armed, the launcher takes whichever event comes first. For serrated formats it starts the output on the first rising edge of the sync, which is the serration that follows the broad pulse. Formats without serrations may not produce that edge in time, so the launcher also counts a default delay from the first low cycle of the vertical stretch and starts the output when the delay runs out. A default-launched pulse can finish while the input is still inside its vertical period. In that case the rising edge that ends the period launches a second pulse.

The threshold, delay and output width are unsigned cycle counts. They are captured while reset is held and then stay fixed until the next reset. All three are control pins with no handshake.

Top module: `vsync_extractor`

## Requirements
- R1: While rst_n is low, vsync is 0 and the three configuration inputs are captured. Changes on those inputs after reset is released have no effect until the next reset.
- R2: The input reaches the detection logic through two flops. When a rising sync edge launches a pulse and the new high level is first sampled at clock edge k, vsync goes high after edge k+2.
- R3: A low stretch is recognised as a broad pulse once it has lasted cfg_thresh consecutive sampled cycles. Shorter stretches, such as horizontal and equalising pulses, never produce output. A threshold of 0 disables recognition.
- R4: After recognition, the first rising input edge launches the pulse if it arrives no later than the cycle in which the default delay expires. On a tie, the rising edge wins.
- R5: If no rising edge has arrived by then, the pulse is launched on the stretch's cfg_delay-th cycle, counting the first low cycle as 1. When the stretch's first low level is sampled at edge f, vsync goes high after edge f+cfg_delay+1. If cfg_delay is at most cfg_thresh, the pulse starts at recognition.
- R6: Every output pulse is high for exactly cfg_width clock cycles. A width of 0 behaves as 1.
- R7: A default-launched pulse may end before the input rises again. In that case the next rising input edge launches a second pulse of the same width. If the input rises while the pulse is still high, including its last cycle, no second pulse follows.
- R8: While the output is high, further broad pulses neither launch nor stretch it. A pulse wide enough to span the broad-pulse train yields exactly one pulse per field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; configuration is captured while low |
| csync_n | input | 1 | Digitized composite sync, active low, asynchronous to clk |
| cfg_thresh | input | CNT_W | Low-time threshold for broad-pulse recognition, in cycles |
| cfg_delay | input | CNT_W | Default launch delay from start of the vertical stretch, in cycles |
| cfg_width | input | CNT_W | Output pulse width, in cycles |
| vsync | output | 1 | Vertical sync pulse, active high |

## Verification
The bench sweeps the default delay across the full length of a two-line unserrated vertical stretch. This catches a launcher that puts the tie between delay expiry and the rising edge on the wrong side, which would emit a spurious second pulse, or one whose retrigger is off by a cycle in either direction. Serrated fields are run with delays and thresholds swept together. A design that rearms after its pulse ends, or that counts elapsed time from recognition instead of from the falling edge, shows up as extra or shifted pulses. Isolated low stretches one cycle short of, equal to and longer than the threshold probe the off-by-one in recognition. Zero width, zero threshold and configuration pins scrambled after reset are also covered: a design that reads the live pins or mishandles zero produces wrong widths or pulses where none belong.

// File: rtl/vsx_pkg.sv
package vsx_pkg;

  // Launcher states
  typedef enum logic [1:0] {
    VS_IDLE  = 2'd0,  // waiting for a broad pulse
    VS_ARMED = 2'd1,  // broad pulse seen, waiting for edge or delay
    VS_PULSE = 2'd2,  // output high
    VS_WAIT  = 2'd3   // default pulse over, input still in vertical period
  } vs_state_e;

  // Idle level of the active-low sync line
  localparam logic SYNC_IDLE = 1'b1;

endpackage

// File: rtl/vsx_sync_edge.sv
module vsx_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise
);
  import vsx_pkg::*;

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // Synchroniser chain, reset to the idle sync level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{SYNC_IDLE}};
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
    end
  end

  // One more register to detect the low-to-high transition
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= SYNC_IDLE;
    end else begin
      prev_q <= chain_q[LAST];
    end
  end

  assign lvl  = chain_q[LAST];
  assign rise = chain_q[LAST] & ~prev_q;

endmodule

// File: rtl/vsx_low_meter.sv
module vsx_low_meter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl,
  input  logic [CNT_W-1:0] thresh,
  output logic             hit
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] run_d;

  // Length of the current low stretch including this cycle, saturating
  always_comb begin
    if (lvl) begin
      run_d = '0;
    end else if (run_q == CMAX) begin
      run_d = CMAX;
    end else begin
      run_d = run_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else begin
      run_q <= run_d;
    end
  end

  // Single-cycle strobe on the cycle the stretch reaches the threshold
  assign hit = !lvl && (thresh != '0) && (run_q != CMAX) && (run_d == thresh);

endmodule

// File: rtl/vsx_pulse_fsm.sv
module vsx_pulse_fsm
  import vsx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             hit,
  input  logic [CNT_W-1:0] thresh,
  input  logic [CNT_W-1:0] delay,
  input  logic [CNT_W-1:0] width,
  output logic             vsync,
  output vs_state_e        state
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  vs_state_e        state_q, state_d;
  logic [CNT_W-1:0] ecnt_q, ecnt_d;
  logic [CNT_W-1:0] wcnt_q, wcnt_d;
  logic [CNT_W-1:0] elapsed;
  logic [CNT_W-1:0] wid_eff;
  logic             pend_q, pend_d;
  logic             out_q, out_d;
  logic             launch;
  logic             launch_dflt;

  always_comb begin
    elapsed     = (ecnt_q == CMAX) ? CMAX : ecnt_q + ONE;
    wid_eff     = (width == '0) ? ONE : width;
    state_d     = state_q;
    ecnt_d      = ecnt_q;
    wcnt_d      = wcnt_q;
    pend_d      = pend_q;
    out_d       = out_q;
    launch      = 1'b0;
    launch_dflt = 1'b0;

    case (state_q)
      VS_IDLE: begin
        if (hit) begin
          if (thresh >= delay) begin
            // delay already used up by the recognition time
            launch      = 1'b1;
            launch_dflt = 1'b1;
          end else begin
            state_d = VS_ARMED;
            ecnt_d  = thresh;  // cycles since the stretch began
          end
        end
      end
      VS_ARMED: begin
        if (rise) begin
          launch = 1'b1;       // serration edge has priority on a tie
        end else if (elapsed >= delay) begin
          launch      = 1'b1;
          launch_dflt = 1'b1;
        end else begin
          ecnt_d = elapsed;
        end
      end
      VS_PULSE: begin
        if (rise) begin
          pend_d = 1'b0;       // input vertical period ended under the pulse
        end
        if (wcnt_q >= wid_eff) begin
          out_d   = 1'b0;
          state_d = (pend_q && !rise) ? VS_WAIT : VS_IDLE;
        end else begin
          wcnt_d = wcnt_q + ONE;
        end
      end
      VS_WAIT: begin
        if (rise) begin
          launch = 1'b1;       // retrigger on the end of the vertical period
        end
      end
      default: begin
        state_d = VS_IDLE;
      end
    endcase

    if (launch) begin
      state_d = VS_PULSE;
      out_d   = 1'b1;
      wcnt_d  = ONE;
      pend_d  = launch_dflt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= VS_IDLE;
      ecnt_q  <= '0;
      wcnt_q  <= '0;
      pend_q  <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ecnt_q  <= ecnt_d;
      wcnt_q  <= wcnt_d;
      pend_q  <= pend_d;
      out_q   <= out_d;
    end
  end

  assign vsync = out_q;
  assign state = state_q;

endmodule

// File: rtl/vsync_extractor.sv
module vsync_extractor
  import vsx_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csync_n,
  input  logic [CNT_W-1:0] cfg_thresh,
  input  logic [CNT_W-1:0] cfg_delay,
  input  logic [CNT_W-1:0] cfg_width,
  output logic             vsync
);

  logic [CNT_W-1:0] thr_q;
  logic [CNT_W-1:0] dly_q;
  logic [CNT_W-1:0] wid_q;
  logic             sync_lvl;
  logic             sync_rise;
  logic             broad_hit;
  vs_state_e        fsm_state;

  // Configuration is sampled only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q <= cfg_thresh;
      dly_q <= cfg_delay;
      wid_q <= cfg_width;
    end
  end

  vsx_sync_edge #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (csync_n),
    .lvl   (sync_lvl),
    .rise  (sync_rise)
  );

  vsx_low_meter #(
    .CNT_W (CNT_W)
  ) u_meter (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl    (sync_lvl),
    .thresh (thr_q),
    .hit    (broad_hit)
  );

  vsx_pulse_fsm #(
    .CNT_W (CNT_W)
  ) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise   (sync_rise),
    .hit    (broad_hit),
    .thresh (thr_q),
    .delay  (dly_q),
    .width  (wid_q),
    .vsync  (vsync),
    .state  (fsm_state)
  );

endmodule

// File: rtl/vsx_checks.sv
module vsx_checks
  import vsx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vsync,
  input vs_state_e        state,
  input logic             rise,
  input logic             hit,
  input logic [CNT_W-1:0] thr_q,
  input logic [CNT_W-1:0] dly_q,
  input logic [CNT_W-1:0] wid_q
);
  localparam logic [CNT_W:0] RMAX = '1;

  logic [CNT_W:0] run_c;
  logic [CNT_W:0] eff_w;

  assign eff_w = (wid_q == '0) ? (CNT_W+1)'(1) : {1'b0, wid_q};

  // Consecutive high cycles of the output seen so far
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_c <= '0;
    end else if (!vsync) begin
      run_c <= '0;
    end else if (run_c != RMAX) begin
      run_c <= run_c + (CNT_W+1)'(1);
    end
  end

  AST_RESET_LOW: assert property (@(posedge clk) !rst_n |=> !vsync); // R1

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(thr_q) && $stable(dly_q) && $stable(wid_q)); // R1

  AST_ZERO_THR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_q == '0) |-> !hit); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == VS_IDLE && !hit) |=> !vsync); // R3

  AST_SERR_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == VS_ARMED && rise) |=> vsync); // R4

  AST_WIDTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |-> (run_c < eff_w)); // R6

  AST_WIDTH_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync) |-> (run_c == eff_w)); // R6

  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == VS_WAIT) |-> !vsync); // R7

  AST_RETRIG_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == VS_WAIT && rise) |=> vsync); // R7

endmodule

bind vsync_extractor vsx_checks #(
  .CNT_W (CNT_W)
) u_vsx_checks (
  .clk   (clk),
  .rst_n (rst_n),
  .vsync (vsync),
  .state (fsm_state),
  .rise  (sync_rise),
  .hit   (broad_hit),
  .thr_q (thr_q),
  .dly_q (dly_q),
  .wid_q (wid_q)
);

// File: tb/tb_vsync_extractor.sv
`timescale 1ns/1ps
module tb_vsync_extractor;

  localparam int CW    = 10;
  localparam int LN    = 40;   // line length in cycles
  localparam int HL    = 20;   // half line
  localparam int FN    = 680;  // serrated field length
  localparam int FV    = 400;  // unserrated field length
  localparam int SLEAD = 20;   // start of isolated stretch

  logic          clk = 1'b0;
  logic          rst_n;
  logic          csync_n;
  logic [CW-1:0] cfg_thresh;
  logic [CW-1:0] cfg_delay;
  logic [CW-1:0] cfg_width;
  logic          vsync;

  always #10 clk = ~clk;  // 50 MHz

  vsync_extractor #(
    .CNT_W       (CW),
    .SYNC_STAGES (2)
  ) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .csync_n    (csync_n),
    .cfg_thresh (cfg_thresh),
    .cfg_delay  (cfg_delay),
    .cfg_width  (cfg_width),
    .vsync      (vsync)
  );

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;
  int    exp_n;
  int    exp_st [8];
  int    exp_w  [8];
  string exp_tag[8];

  // Sync level driven during bench cycle t
  function automatic logic model(int fmt, int t, int len);
    int p;
    if (fmt == 0) begin
      if (t >= 2*FN) return 1'b1;
      p = t % FN;
      if (p < 4*LN)             return !((p % LN) < 3);
      if (p < 4*LN + 6*HL)      return !(((p - 4*LN) % HL) < 2);
      if (p < 4*LN + 12*HL)     return !(((p - 4*LN - 6*HL) % HL) < 17);
      if (p < 4*LN + 18*HL)     return !(((p - 4*LN - 12*HL) % HL) < 2);
      return !(((p - 4*LN - 18*HL) % LN) < 3);
    end else if (fmt == 1) begin
      if (t >= 2*FV) return 1'b1;
      p = t % FV;
      if (p < 4*LN)      return !((p % LN) < 4);
      if (p < 4*LN + 80) return 1'b0;
      return !((((p - 240) % LN) >= 20) && (((p - 240) % LN) < 24));
    end
    return !((t >= SLEAD) && (t < SLEAD + len));
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run_case(int fmt, int thr, int dly, int wid, int len,
                          int cycles, string ctag);
    int   st[8];
    int   wd[8];
    int   nr;
    logic lastv;
    logic v;
    rst_n      = 1'b0;
    csync_n    = 1'b1;
    cfg_thresh = CW'(thr);
    cfg_delay  = CW'(dly);
    cfg_width  = CW'(wid);
    repeat (3) @(negedge clk);
    chk(vsync === 1'b0, "R1", "output in reset", int'(vsync), 0);
    rst_n      = 1'b1;
    // R1: live configuration pins must no longer matter
    cfg_thresh = ~CW'(thr);
    cfg_delay  = ~CW'(dly);
    cfg_width  = CW'(wid + 3);
    nr    = 0;
    lastv = 1'b0;
    for (int i = 0; i < 8; i++) begin
      st[i] = -1;
      wd[i] = -1;
    end
    for (int t = 0; t < cycles; t++) begin
      @(negedge clk);
      v = vsync;
      if (v && !lastv) begin
        if (nr < 8) st[nr] = t;
        nr++;
      end else if (!v && lastv && nr <= 8) begin
        wd[nr-1] = t - st[nr-1];
      end
      lastv   = v;
      csync_n = model(fmt, t, len);
    end
    chk(nr == exp_n, ctag, "pulse count", nr, exp_n);
    for (int i = 0; i < exp_n && i < nr && i < 8; i++) begin
      chk(st[i] == exp_st[i], exp_tag[i], "pulse start", st[i], exp_st[i]);
      chk(wd[i] == exp_w[i], "R6", "pulse width", wd[i], exp_w[i]);
    end
  endtask

  initial begin
    rst_n      = 1'b0;
    csync_n    = 1'b1;
    cfg_thresh = '0;
    cfg_delay  = '0;
    cfg_width  = '0;

    // Serrated fields, delay sweep: launch on first serration (R4), one per field (R8)
    for (int d = 18; d <= 40; d++) begin
      exp_n = 2;
      for (int k = 0; k < 2; k++) begin
        exp_st[k] = k*FN + 300; exp_w[k] = 100 + (d % 4)*25; exp_tag[k] = "R4";
      end
      run_case(0, 10, d, 100 + (d % 4)*25, 0, 2*FN, "R8");
    end

    // Serrated fields, threshold sweep (R3, R8)
    for (int th = 4; th <= 17; th++) begin
      exp_n = 2;
      for (int k = 0; k < 2; k++) begin
        exp_st[k] = k*FN + 300; exp_w[k] = 120; exp_tag[k] = "R4";
      end
      run_case(0, th, 30, 120, 0, 2*FN, "R3");
    end

    // Two-line unserrated vertical stretch: default launch (R5), retrigger (R7)
    for (int d = 0; d <= 95; d++) begin
      int w;
      int de;
      w  = 1 + (d*13) % 90;
      de = (d < 10) ? 10 : d;
      exp_n = 0;
      for (int k = 0; k < 2; k++) begin
        if (de >= 81) begin
          exp_st[exp_n] = k*FV + 243; exp_w[exp_n] = w; exp_tag[exp_n] = "R4";
          exp_n++;
        end else begin
          exp_st[exp_n] = k*FV + 160 + de + 2; exp_w[exp_n] = w; exp_tag[exp_n] = "R5";
          exp_n++;
          if (w < 81 - de) begin
            exp_st[exp_n] = k*FV + 243; exp_w[exp_n] = w; exp_tag[exp_n] = "R7";
            exp_n++;
          end
        end
      end
      run_case(1, 10, d, w, 0, 2*FV, "R7");
    end

    // Zero threshold disables recognition (R3)
    exp_n = 0;
    run_case(1, 0, 40, 20, 0, 2*FV, "R3");

    // Isolated stretches around the threshold; latency (R2), boundary (R3)
    foreach (exp_w[j]) exp_w[j] = 5;
    for (int ti = 0; ti < 3; ti++) begin
      int th;
      th = (ti == 0) ? 1 : ((ti == 1) ? 3 : 8);
      for (int n = 1; n <= th + 2; n++) begin
        if (n >= th) begin
          exp_n = 1; exp_st[0] = SLEAD + n + 3; exp_w[0] = 5; exp_tag[0] = "R2";
        end else begin
          exp_n = 0;
        end
        run_case(2, th, 1023, 5, n, 120, "R3");
      end
    end

    // Zero width behaves as one cycle (R6)
    exp_n = 1; exp_st[0] = SLEAD + 6 + 3; exp_w[0] = 1; exp_tag[0] = "R6";
    run_case(2, 3, 1023, 0, 6, 120, "R6");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule